// File: doc/BRIEF.md
# CAN controller mode sequencer

This block is the mode and configuration front end of a CAN controller. Software reaches it through a plain 32-bit register bus: a single-cycle write strobe with address and data, and a combinational read path. It holds the enable and soft-reset controls, the mode selection, the baud prescaler and the bit-timing fields. It also tracks the operating mode (configuration, normal, loopback or sleep) and reports it as one-hot status bits that software polls after it sets the enable bit.

The bit engine itself lies outside this block. It sees only an engine enable, a loopback indication and the latched timing fields. The timing registers are protected: they accept writes only while the block reports configuration mode, so the engine never sees its timing change under it. A bus-off event from the engine drops the block back into configuration mode exactly as a soft reset does.

Top module: `can_mode_seq`

## Requirements
- R1: After reset the status register (offset 0x18) reads exactly 0x00000001 (configuration bit only), and the control (0x00), mode select (0x04), prescaler (0x08) and timing (0x0C) registers read zero. Unmapped offsets read zero.
- R2: A write to offset 0x00 with bit 0 set is a soft reset. It clears enable, mode select, prescaler and timing, and the status reads 0x1 after the next clock edge. Soft reset wins over bit 1 in the same write, and bit 0 always reads back as 0.
- R3: Bit 1 of offset 0x00 is the enable and reads back at bit 1. Once it is set with mode select at zero, status reads 0x8 (bit 3, normal) after the second rising edge following the write, and still reads 0x1 after the first.
- R4: Mode select bit 1 at offset 0x04 selects loopback. With enable set, status reads 0x2 (bit 1), and loopback takes precedence over sleep when both bits are set.
- R5: Mode select bit 0 alone selects sleep. With enable set, status reads 0x4 (bit 2).
- R6: Exactly one of status bits 3:0 is set in every cycle, and all other status bits read zero.
- R7: The prescaler sits at offset 0x08, bits 7:0. The timing register at offset 0x0C holds segment 1 in bits 3:0, segment 2 in bits 6:4 and jump width in bits 8:7. Each value is stored and output as written (value minus one), and unused bits read zero.
- R8: Writes to 0x08 or 0x0C made while status does not show configuration mode are ignored, and the registers keep their old values.
- R9: Clearing the enable bit returns status to 0x1 one clock after the enable register clears.
- R10: A high bus-off input at a clock edge has the same effect as a soft reset.
- R11: The engine enable output is high exactly while status shows normal or loopback, and the loopback output is high exactly while it shows loopback.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | ADDR_W | Byte address of the register |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data for `addr` (combinational) |
| bus_off | input | 1 | Bus-off event from the bit engine |
| engine_en | output | 1 | Bit engine enable |
| loopback | output | 1 | Engine loopback indication |
| brp | output | BRP_W | Prescaler field (value minus one) |
| tseg1 | output | 4 | Segment 1 field (value minus one) |
| tseg2 | output | 3 | Segment 2 field (value minus one) |
| sjw | output | 2 | Jump width field (value minus one) |

## Verification
The hardest case to reach is the one-cycle window after enable is written. The enable register is already set, but status still shows configuration mode, so a timing write in that cycle must be accepted while the same write one cycle later must be dropped. The stimulus issues the enable write followed by back-to-back prescaler and timing writes, so that one lands inside the window and one lands outside it. A behavioural model compares every output and the read data on every clock. The stimulus also covers bus-off arriving in the same cycle as a mode change, and a soft reset written together with enable.

// File: rtl/can_mode_seq.sv
module can_mode_seq #(
  parameter int ADDR_W = 8,
  parameter int BRP_W  = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              bus_off,
  output logic              engine_en,
  output logic              loopback,
  output logic [BRP_W-1:0]  brp,
  output logic [3:0]        tseg1,
  output logic [2:0]        tseg2,
  output logic [1:0]        sjw
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_MSEL = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_BRP  = ADDR_W'(8'h08);
  localparam logic [ADDR_W-1:0] A_TIM  = ADDR_W'(8'h0C);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(8'h18);
  localparam int TIM_W = 9;

  localparam logic [3:0] M_CFG   = 4'b0001;
  localparam logic [3:0] M_LOOP  = 4'b0010;
  localparam logic [3:0] M_SLEEP = 4'b0100;
  localparam logic [3:0] M_NORM  = 4'b1000;

  logic             en_q;
  logic [1:0]       sel_q;
  logic [BRP_W-1:0] brp_q;
  logic [TIM_W-1:0] tim_q;
  logic [3:0]       mode_q;
  logic [3:0]       mode_nx;
  logic             srst;
  logic             in_cfg;

  assign srst   = bus_off | (wr_en && addr == A_CTRL && wdata[0]);
  assign in_cfg = mode_q[0];

  always_comb begin
    if (!en_q)         mode_nx = M_CFG;
    else if (sel_q[1]) mode_nx = M_LOOP;
    else if (sel_q[0]) mode_nx = M_SLEEP;
    else               mode_nx = M_NORM;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      brp_q  <= '0;
      tim_q  <= '0;
      mode_q <= M_CFG;
    end else if (srst) begin
      en_q   <= 1'b0;
      sel_q  <= '0;
      brp_q  <= '0;
      tim_q  <= '0;
      mode_q <= M_CFG;
    end else begin
      mode_q <= mode_nx;
      if (wr_en && addr == A_CTRL) en_q  <= wdata[1];
      if (wr_en && addr == A_MSEL) sel_q <= wdata[1:0];
      if (wr_en && addr == A_BRP && in_cfg) brp_q <= wdata[BRP_W-1:0];
      if (wr_en && addr == A_TIM && in_cfg) tim_q <= wdata[TIM_W-1:0];
    end
  end

  always_comb begin
    rdata = '0;
    case (addr)
      A_CTRL:  rdata[1]         = en_q;
      A_MSEL:  rdata[1:0]       = sel_q;
      A_BRP:   rdata[BRP_W-1:0] = brp_q;
      A_TIM:   rdata[TIM_W-1:0] = tim_q;
      A_STAT:  rdata[3:0]       = mode_q;
      default: rdata            = '0;
    endcase
  end

  assign engine_en = mode_q[1] | mode_q[3];
  assign loopback  = mode_q[1];
  assign brp       = brp_q;
  assign tseg1     = tim_q[3:0];
  assign tseg2     = tim_q[6:4];
  assign sjw       = tim_q[8:7];

  assert_one_mode_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(mode_q) == 1);

  assert_timing_locked_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && (addr == A_TIM || addr == A_BRP) && !mode_q[0] && !bus_off)
      |=> ($stable(tim_q) && $stable(brp_q)));

  assert_busoff_cfg_R10: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off |=> (mode_q == M_CFG && !en_q && sel_q == 2'b00));

  assert_disable_cfg_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !en_q |=> mode_q[0]);

  assert_enable_leaves_cfg_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (en_q && !srst) |=> !mode_q[0]);

endmodule

// File: tb/can_mode_seq_tb.sv
module can_mode_seq_tb;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [7:0]  addr = 8'h00;
  logic [31:0] wdata = '0;
  logic        bus_off = 1'b0;
  logic [31:0] rdata;
  logic        engine_en, loopback;
  logic [7:0]  brp;
  logic [3:0]  tseg1;
  logic [2:0]  tseg2;
  logic [1:0]  sjw;

  int tests = 0;
  int fails = 0;
  string tag = "R1";

  always #(CLK_PERIOD/2) clk = ~clk;

  can_mode_seq u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .bus_off(bus_off), .engine_en(engine_en),
    .loopback(loopback), .brp(brp), .tseg1(tseg1), .tseg2(tseg2), .sjw(sjw)
  );

  // behavioural model: mode code 0 cfg, 1 loopback, 2 sleep, 3 normal
  int m_en = 0, m_sel = 0, m_brp = 0, m_tim = 0, m_mode = 0;

  always @(posedge clk) begin
    int nxt;
    if (!rst_n) begin
      m_en = 0; m_sel = 0; m_brp = 0; m_tim = 0; m_mode = 0;
    end else if (bus_off || (wr_en && addr == 8'h00 && wdata[0])) begin
      m_en = 0; m_sel = 0; m_brp = 0; m_tim = 0; m_mode = 0;
    end else begin
      if (m_en == 0) nxt = 0;
      else if (m_sel >= 2) nxt = 1;
      else if (m_sel == 1) nxt = 2;
      else nxt = 3;
      if (wr_en && addr == 8'h00) m_en = int'(wdata[1]);
      if (wr_en && addr == 8'h04) m_sel = int'(wdata[1:0]);
      if (wr_en && addr == 8'h08 && m_mode == 0) m_brp = int'(wdata[7:0]);
      if (wr_en && addr == 8'h0C && m_mode == 0) m_tim = int'(wdata[8:0]);
      m_mode = nxt;
    end
  end

  function automatic logic [31:0] model_read(input logic [7:0] a);
    case (a)
      8'h00: return 32'(m_en * 2);
      8'h04: return 32'(m_sel);
      8'h08: return 32'(m_brp);
      8'h0C: return 32'(m_tim);
      8'h18: return 32'(1 << m_mode);
      default: return 32'h0;
    endcase
  endfunction

  task automatic check(input string what, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual 0x%08h expected 0x%08h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all();
    check("rdata", rdata, model_read(addr));
    check("engine_en", 32'(engine_en), 32'(m_mode == 1 || m_mode == 3));
    check("loopback", 32'(loopback), 32'(m_mode == 1));
    check("brp", 32'(brp), 32'(m_brp & 8'hFF));
    check("tseg1", 32'(tseg1), 32'(m_tim & 15));
    check("tseg2", 32'(tseg2), 32'((m_tim >> 4) & 7));
    check("sjw", 32'(sjw), 32'((m_tim >> 7) & 3));
  endtask

  task automatic cyc(input logic w, input logic [7:0] a, input logic [31:0] d, input logic b);
    @(negedge clk);
    wr_en = w; addr = a; wdata = d; bus_off = b;
    #1;
    compare_all();
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    cyc(1'b1, a, d, 1'b0);
  endtask

  task automatic rd_expect(input logic [7:0] a, input logic [31:0] exp, input string what);
    cyc(1'b0, a, 32'h0, 1'b0);
    check(what, rdata, exp);
  endtask

  initial begin : watchdog
    #(CLK_PERIOD * 150000);
    fails++;
    $display("FAIL watchdog expired");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    tag = "R1";
    rd_expect(8'h18, 32'h1, "status after reset");
    rd_expect(8'h00, 32'h0, "ctrl after reset");
    rd_expect(8'h0C, 32'h0, "timing after reset");
    rd_expect(8'h30, 32'h0, "unmapped");

    tag = "R7";
    wr(8'h08, 32'hFFFF_FF13);
    wr(8'h0C, 32'hFFFF_FFFF);
    rd_expect(8'h0C, 32'h1FF, "timing masked");
    wr(8'h0C, 32'h0000_00A5);
    rd_expect(8'h08, 32'h13, "prescaler");
    rd_expect(8'h0C, 32'hA5, "timing fields");

    tag = "R3";
    wr(8'h00, 32'h2);
    rd_expect(8'h18, 32'h1, "status one edge after enable");
    rd_expect(8'h18, 32'h8, "status normal");
    rd_expect(8'h00, 32'h2, "enable readback");

    tag = "R8";
    wr(8'h08, 32'h55);
    wr(8'h0C, 32'h0F);
    rd_expect(8'h08, 32'h13, "prescaler locked");
    rd_expect(8'h0C, 32'hA5, "timing locked");

    tag = "R9";
    wr(8'h00, 32'h0);
    rd_expect(8'h18, 32'h8, "still normal one edge after clear");
    rd_expect(8'h18, 32'h1, "back to config");

    tag = "R8";
    wr(8'h00, 32'h2);
    wr(8'h08, 32'h77);
    wr(8'h0C, 32'h33);
    rd_expect(8'h08, 32'h77, "write in window accepted");
    rd_expect(8'h0C, 32'hA5, "write after window dropped");

    tag = "R4";
    wr(8'h04, 32'h3);
    rd_expect(8'h18, 32'h8, "pending loopback");
    rd_expect(8'h18, 32'h2, "loopback over sleep");
    tag = "R11";
    check("loopback out", 32'(loopback), 32'h1);
    check("engine on", 32'(engine_en), 32'h1);

    tag = "R5";
    wr(8'h04, 32'h1);
    rd_expect(8'h18, 32'h2, "pending sleep");
    rd_expect(8'h18, 32'h4, "sleep");
    tag = "R11";
    check("engine off in sleep", 32'(engine_en), 32'h0);

    tag = "R10";
    cyc(1'b1, 8'h04, 32'h0, 1'b1);
    rd_expect(8'h18, 32'h1, "bus-off to config");
    rd_expect(8'h00, 32'h0, "bus-off clears enable");
    rd_expect(8'h08, 32'h0, "bus-off clears prescaler");

    tag = "R2";
    wr(8'h08, 32'h21);
    wr(8'h04, 32'h2);
    wr(8'h00, 32'h2);
    rd_expect(8'h18, 32'h1, "pending");
    rd_expect(8'h18, 32'h2, "loopback before reset");
    wr(8'h00, 32'h3);
    rd_expect(8'h18, 32'h1, "soft reset to config");
    rd_expect(8'h00, 32'h0, "reset wins, bit0 reads 0");
    rd_expect(8'h04, 32'h0, "mode select cleared");
    rd_expect(8'h08, 32'h0, "prescaler cleared");

    tag = "R6";
    for (int i = 0; i < 40; i++) begin
      cyc(i % 3 == 0, (i % 2 == 0) ? 8'h00 : 8'h04, 32'(i * 7), i == 29);
      check("one-hot", 32'($countones(u_dut.rdata[3:0]) == 1 || addr != 8'h18), 32'h1);
    end
    rd_expect(8'h18, model_read(8'h18), "final status");

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule